// File: doc/BRIEF.md
# Expansion Port Register Decoder

This block is the I/O front end of a retro computer expansion interface. It sits on an 8-bit CPU I/O bus with a 16-bit port address. It claims three ports by looking at two address bits. The first is a line port that carries the serial transmit line and the network line. The second is a control port: writes set the output control register and reads return a status byte. The third is a drive data port, which passes data straight through to a cartridge drive data channel. Cycles it does not claim raise a pass-through flag, so that a downstream device can answer them.

The output control register is kept in active-low form. A write to it is compared with the stored value. Single-cycle strobes go to the drive controller and to the serial transceiver only when their bit groups actually change. A network wait pulse is issued on every write that requests it. One control bit sets where a line-port write goes: to the serial transmit line or to the network line. A read of the line port samples the network line only while the serial clear-to-send signal is inactive.

The drive data channel has no back-pressure. A write beat is offered with a one-cycle `dd_wr_valid` and must be taken in that cycle. A read is requested with a one-cycle `dd_rd_req`, and the drive must present `dd_rd_data` in the same cycle. All strobes and the bus read data are combinational within the bus cycle. Register updates take effect at the clock edge that ends the cycle.

Top module: `xbus_port_decoder`

## Requirements
- R1: Only the bits `bus_addr[4:3]` select a port: 2'b10 is the line port, 2'b01 is the control port, 2'b00 is the drive data port and 2'b11 is unclaimed. All other address bits are ignored.
- R2: After the synchronous reset the control register holds 0xEE, which gives the levels drv_comms=1, drv_clk=0, drv_write=0, drv_erase=0 and ser_cts=1. A status read returns 0xE7 when all status inputs are 0. A line read returns 0x7E when ser_rxd_in=1.
- R3: A control write pulses `drv_ctl_stb` in that cycle only if `bus_wdata[3:0]` differs from the stored bits. The level outputs drv_comms, drv_clk, drv_write and drv_erase are the inverses of bits 0, 1, 2 and 3 of the new value.
- R4: A control write pulses `cts_stb` only if bit 4 changes. `ser_cts` is the inverse of bit 4.
- R5: Every control write with `bus_wdata[5]`=0 pulses `net_wait_stb`, even when the stored bit is already 0.
- R6: A status read returns {3'b111, net_busy_in, dtr_bit, ~md_gap, ~md_sync, ~md_wprot}. Here dtr_bit is 0 when DTR was last seen active.
- R7: A line-port write drives `~bus_wdata[0]`. It goes to `ser_tx_data` with `ser_tx_stb` when stored control bit 0 is 1. Otherwise it goes to `net_tx_data` with `net_tx_stb`.
- R8: A line read returns {~ser_rxd_in, 6'b111111, net_bit}. While stored control bit 4 is 1, net_bit takes and keeps `net_line_in`. While bit 4 is 0, net_bit keeps its previous value.
- R9: dtr_bit loads ~ser_dtr_in on a line write routed to serial and on `frame_tick`, and holds at all other times.
- R10: Drive data port writes pulse `dd_wr_valid` with `dd_wr_data`=`bus_wdata`. Reads pulse `dd_rd_req` and return `dd_rd_data` on the bus.
- R11: An unclaimed cycle raises `pass_thru`, keeps `bus_rdata_en` low, fires no strobe and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | I/O port address |
| bus_rd | input | 1 | I/O read cycle |
| bus_wr | input | 1 | I/O write cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for claimed ports |
| bus_rdata_en | output | 1 | Block drives read data this cycle |
| pass_thru | output | 1 | Cycle is left to the downstream device |
| frame_tick | input | 1 | Frame boundary, refreshes DTR |
| md_gap | input | 1 | Drive reports gap |
| md_sync | input | 1 | Drive reports sync |
| md_wprot | input | 1 | Drive reports write protect |
| net_busy_in | input | 1 | Network busy status bit |
| ser_rxd_in | input | 1 | Serial receive data level |
| ser_dtr_in | input | 1 | Serial DTR active |
| net_line_in | input | 1 | Network line level |
| drv_ctl_stb | output | 1 | Drive control changed |
| drv_erase | output | 1 | Erase active |
| drv_write | output | 1 | Write mode active |
| drv_clk | output | 1 | Comms clock active |
| drv_comms | output | 1 | Comms-out active |
| cts_stb | output | 1 | CTS changed |
| ser_cts | output | 1 | CTS active |
| net_wait_stb | output | 1 | Network wait request |
| ser_tx_stb | output | 1 | Serial transmit update |
| ser_tx_data | output | 1 | Serial transmit level |
| net_tx_stb | output | 1 | Network line update |
| net_tx_data | output | 1 | Network line level |
| dd_wr_valid | output | 1 | Drive data write beat |
| dd_wr_data | output | 8 | Drive data write byte |
| dd_rd_req | output | 1 | Drive data read request |
| dd_rd_data | input | 8 | Drive data read byte |

## Verification
A wrong stored control bit shows up at once on the level outputs. It also changes which strobes fire on the next control write, and it moves the next line write to the wrong line. A wrong network or DTR bit stays hidden until the next line or status read, so the bench reads after every event that may or may not touch those bits. Held values and refreshed values are thus told apart within one bus cycle of the stimulus.

// File: rtl/xpd_pkg.sv
package xpd_pkg;
  typedef enum logic [1:0] {
    PORT_DATA = 2'b00,
    PORT_CTRL = 2'b01,
    PORT_LINE = 2'b10,
    PORT_NONE = 2'b11
  } port_sel_e;

  localparam int CTRL_W   = 6;
  localparam int CB_COMMS = 0;
  localparam int CB_CLK   = 1;
  localparam int CB_RW    = 2;
  localparam int CB_ERASE = 3;
  localparam int CB_CTS   = 4;
  localparam int CB_WAIT  = 5;
  localparam logic [CTRL_W-1:0] CTRL_RST = 6'b10_1110;
endpackage

// File: rtl/xpd_decode.sv
module xpd_decode #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] SEL_MASK = 16'h0018,
  parameter int SEL_LO = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  output xpd_pkg::port_sel_e sel,
  output logic              line_rd,
  output logic              line_wr,
  output logic              ctl_rd,
  output logic              ctl_wr,
  output logic              dat_rd,
  output logic              dat_wr,
  output logic              pass
);
  import xpd_pkg::*;

  logic [ADDR_W-1:0] masked;
  logic [1:0]        code;

  always_comb begin
    masked = addr & SEL_MASK;
    code   = masked[SEL_LO +: 2];
    sel    = port_sel_e'(code);
  end

  always_comb begin
    line_rd = rd && (sel == PORT_LINE);
    line_wr = wr && (sel == PORT_LINE);
    ctl_rd  = rd && (sel == PORT_CTRL);
    ctl_wr  = wr && (sel == PORT_CTRL);
    dat_rd  = rd && (sel == PORT_DATA);
    dat_wr  = wr && (sel == PORT_DATA);
    pass    = (rd || wr) && (sel == PORT_NONE);
  end

  // R1: one target at most per read and per write
  p_one_target_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0({line_wr, ctl_wr, dat_wr}) && $onehot0({line_rd, ctl_rd, dat_rd}));
endmodule

// File: rtl/xpd_ctrl_reg.sv
module xpd_ctrl_reg
  import xpd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [CTRL_W-1:0] wdata,
  output logic              comms_sel,
  output logic              cts_idle,
  output logic              drv_stb,
  output logic              cts_stb,
  output logic              wait_stb,
  output logic [3:0]        drv_act,
  output logic              cts_act
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [CTRL_W-1:0] diff;
  logic [CTRL_W-1:0] eff;

  always_ff @(posedge clk) begin
    if (rst)     ctrl_q <= CTRL_RST;
    else if (wr) ctrl_q <= wdata;
  end

  always_comb begin
    diff     = wr ? (ctrl_q ^ wdata) : '0;
    eff      = wr ? wdata : ctrl_q;
    drv_stb  = |diff[CB_ERASE:CB_COMMS];
    cts_stb  = diff[CB_CTS];
    wait_stb = wr && !wdata[CB_WAIT];
    drv_act  = ~eff[CB_ERASE:CB_COMMS];
    cts_act  = ~eff[CB_CTS];
    comms_sel = ctrl_q[CB_COMMS];
    cts_idle  = ctrl_q[CB_CTS];
  end

  // R3: the drive strobe implies the low nibble moved
  p_drv_change_r3: assert property (@(posedge clk) disable iff (rst)
    drv_stb |=> ctrl_q[3:0] != $past(ctrl_q[3:0]));
  // R3: a write without the drive strobe leaves the nibble alone
  p_drv_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (wr && !drv_stb) |=> $stable(ctrl_q[3:0]));
  // R4: the CTS strobe implies bit 4 toggled
  p_cts_change_r4: assert property (@(posedge clk) disable iff (rst)
    cts_stb |=> ctrl_q[CB_CTS] != $past(ctrl_q[CB_CTS]));
  // R5: the wait pulse leaves the wait bit at 0
  p_wait_bit_r5: assert property (@(posedge clk) disable iff (rst)
    wait_stb |=> !ctrl_q[CB_WAIT]);
  // R11: no write, no change
  p_ctrl_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(ctrl_q));
endmodule

// File: rtl/xpd_line_status.sv
module xpd_line_status #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_wr,
  input  logic              line_rd,
  input  logic              wbit,
  input  logic              comms_sel,
  input  logic              cts_idle,
  input  logic              frame_tick,
  input  logic              ser_rxd_in,
  input  logic              ser_dtr_in,
  input  logic              net_line_in,
  input  logic              net_busy_in,
  input  logic              md_gap,
  input  logic              md_sync,
  input  logic              md_wprot,
  output logic [DATA_W-1:0] line_byte,
  output logic [DATA_W-1:0] stat_byte,
  output logic              ser_tx_stb,
  output logic              ser_tx_data,
  output logic              net_tx_stb,
  output logic              net_tx_data
);
  localparam int LINE_FILL = DATA_W - 2;
  localparam int STAT_FILL = DATA_W - 5;

  logic net_q;
  logic dtr_bit;
  logic net_now;
  logic dtr_load;

  always_comb begin
    net_now  = cts_idle ? net_line_in : net_q;
    dtr_load = frame_tick || (line_wr && comms_sel);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      net_q   <= 1'b0;
      dtr_bit <= 1'b0;
    end else begin
      if (line_rd && cts_idle) net_q <= net_line_in;
      if (dtr_load) dtr_bit <= !ser_dtr_in;
    end
  end

  always_comb begin
    line_byte   = {!ser_rxd_in, {LINE_FILL{1'b1}}, net_now};
    stat_byte   = {{STAT_FILL{1'b1}}, net_busy_in, dtr_bit, !md_gap, !md_sync, !md_wprot};
    ser_tx_stb  = line_wr && comms_sel;
    net_tx_stb  = line_wr && !comms_sel;
    ser_tx_data = !wbit;
    net_tx_data = !wbit;
  end

  // R8: the network bit is held unless sampled with CTS idle
  p_net_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !(line_rd && cts_idle) |=> $stable(net_q));
  // R9: the DTR bit is held without a refresh event
  p_dtr_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !(frame_tick || ser_tx_stb) |=> $stable(dtr_bit));
  // R7: exactly one line receives a line write
  p_route_r7: assert property (@(posedge clk) disable iff (rst)
    line_wr |-> $onehot({ser_tx_stb, net_tx_stb}));
endmodule

// File: rtl/xbus_port_decoder.sv
module xbus_port_decoder
  import xpd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rdata_en,
  output logic              pass_thru,
  input  logic              frame_tick,
  input  logic              md_gap,
  input  logic              md_sync,
  input  logic              md_wprot,
  input  logic              net_busy_in,
  input  logic              ser_rxd_in,
  input  logic              ser_dtr_in,
  input  logic              net_line_in,
  output logic              drv_ctl_stb,
  output logic              drv_erase,
  output logic              drv_write,
  output logic              drv_clk,
  output logic              drv_comms,
  output logic              cts_stb,
  output logic              ser_cts,
  output logic              net_wait_stb,
  output logic              ser_tx_stb,
  output logic              ser_tx_data,
  output logic              net_tx_stb,
  output logic              net_tx_data,
  output logic              dd_wr_valid,
  output logic [DATA_W-1:0] dd_wr_data,
  output logic              dd_rd_req,
  input  logic [DATA_W-1:0] dd_rd_data
);
  port_sel_e         sel;
  logic              line_rd, line_wr, ctl_rd, ctl_wr, dat_rd, dat_wr;
  logic              comms_sel, cts_idle;
  logic [3:0]        drv_act;
  logic [DATA_W-1:0] line_byte, stat_byte;

  xpd_decode #(.ADDR_W(ADDR_W)) u_decode (
    .clk(clk), .rst(rst), .addr(bus_addr), .rd(bus_rd), .wr(bus_wr),
    .sel(sel), .line_rd(line_rd), .line_wr(line_wr), .ctl_rd(ctl_rd),
    .ctl_wr(ctl_wr), .dat_rd(dat_rd), .dat_wr(dat_wr), .pass(pass_thru)
  );

  xpd_ctrl_reg u_ctrl (
    .clk(clk), .rst(rst), .wr(ctl_wr), .wdata(bus_wdata[CTRL_W-1:0]),
    .comms_sel(comms_sel), .cts_idle(cts_idle), .drv_stb(drv_ctl_stb),
    .cts_stb(cts_stb), .wait_stb(net_wait_stb), .drv_act(drv_act),
    .cts_act(ser_cts)
  );

  xpd_line_status #(.DATA_W(DATA_W)) u_line (
    .clk(clk), .rst(rst), .line_wr(line_wr), .line_rd(line_rd),
    .wbit(bus_wdata[0]), .comms_sel(comms_sel), .cts_idle(cts_idle),
    .frame_tick(frame_tick), .ser_rxd_in(ser_rxd_in), .ser_dtr_in(ser_dtr_in),
    .net_line_in(net_line_in), .net_busy_in(net_busy_in), .md_gap(md_gap),
    .md_sync(md_sync), .md_wprot(md_wprot), .line_byte(line_byte),
    .stat_byte(stat_byte), .ser_tx_stb(ser_tx_stb), .ser_tx_data(ser_tx_data),
    .net_tx_stb(net_tx_stb), .net_tx_data(net_tx_data)
  );

  always_comb begin
    drv_comms   = drv_act[CB_COMMS];
    drv_clk     = drv_act[CB_CLK];
    drv_write   = drv_act[CB_RW];
    drv_erase   = drv_act[CB_ERASE];
    dd_wr_valid = dat_wr;
    dd_wr_data  = bus_wdata;
    dd_rd_req   = dat_rd;
    bus_rdata_en = line_rd || ctl_rd || dat_rd;
    unique case (sel)
      PORT_LINE: bus_rdata = line_byte;
      PORT_CTRL: bus_rdata = stat_byte;
      PORT_DATA: bus_rdata = dd_rd_data;
      default:   bus_rdata = '0;
    endcase
  end

  // R11: an unclaimed cycle touches nothing
  p_unclaimed_r11: assert property (@(posedge clk) disable iff (rst)
    pass_thru |-> !bus_rdata_en && !dd_wr_valid && !dd_rd_req &&
                  !drv_ctl_stb && !cts_stb && !net_wait_stb &&
                  !ser_tx_stb && !net_tx_stb);
  // R7: the serial line is used only while comms-out is inactive
  p_ser_route_r7: assert property (@(posedge clk) disable iff (rst)
    ser_tx_stb |-> !drv_comms);
endmodule

// File: tb/xbus_port_decoder_tb_top.sv
`timescale 1ns/1ps
module xbus_port_decoder_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic bus_rdata_en, pass_thru;
  logic frame_tick = 0, md_gap = 0, md_sync = 0, md_wprot = 0, net_busy_in = 0;
  logic ser_rxd_in = 1, ser_dtr_in = 0, net_line_in = 0;
  logic drv_ctl_stb, drv_erase, drv_write, drv_clk, drv_comms, cts_stb, ser_cts;
  logic net_wait_stb, ser_tx_stb, ser_tx_data, net_tx_stb, net_tx_data;
  logic dd_wr_valid, dd_rd_req;
  logic [7:0] dd_wr_data;
  logic [7:0] dd_rd_data = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] ctrl_m = 8'hEE;
  logic net_m = 0, dtr_m = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  xbus_port_decoder dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rdata_en(bus_rdata_en),
    .pass_thru(pass_thru), .frame_tick(frame_tick), .md_gap(md_gap),
    .md_sync(md_sync), .md_wprot(md_wprot), .net_busy_in(net_busy_in),
    .ser_rxd_in(ser_rxd_in), .ser_dtr_in(ser_dtr_in), .net_line_in(net_line_in),
    .drv_ctl_stb(drv_ctl_stb), .drv_erase(drv_erase), .drv_write(drv_write),
    .drv_clk(drv_clk), .drv_comms(drv_comms), .cts_stb(cts_stb), .ser_cts(ser_cts),
    .net_wait_stb(net_wait_stb), .ser_tx_stb(ser_tx_stb), .ser_tx_data(ser_tx_data),
    .net_tx_stb(net_tx_stb), .net_tx_data(net_tx_data), .dd_wr_valid(dd_wr_valid),
    .dd_wr_data(dd_wr_data), .dd_rd_req(dd_rd_req), .dd_rd_data(dd_rd_data)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read bytes as the design answers
  always @(negedge clk) begin
    if (!rst && bus_rd && bus_rdata_en) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL unexpected read actual=%02h expected=none", bus_rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, bus_rdata, e);
      end
    end
  end

  task automatic push(string tag, logic [7:0] e);
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic check_levels(string tag);
    logic [7:0] lv, ex;
    lv = {3'b000, ser_cts, drv_erase, drv_write, drv_clk, drv_comms};
    ex = {3'b000, ~ctrl_m[4], ~ctrl_m[3], ~ctrl_m[2], ~ctrl_m[1], ~ctrl_m[0]};
    check(tag, lv, ex);
  endtask

  task automatic wr_ctrl(logic [7:0] d);
    logic [7:0] chg;
    logic [3:0] nf;
    logic any_lo, c4, w5, cl;
    @(posedge clk); #1;
    bus_addr = 16'hA50D; bus_wdata = d; bus_wr = 1;
    chg = ctrl_m ^ d;
    nf = ~d[3:0];
    any_lo = |chg[3:0];
    c4 = chg[4];
    w5 = ~d[5];
    cl = ~d[4];
    @(negedge clk);
    check("R3 drive strobe", drv_ctl_stb, any_lo);
    if (any_lo) check("R3 drive fields", {drv_erase, drv_write, drv_clk, drv_comms}, nf);
    check("R4 cts strobe", cts_stb, c4);
    check("R4 cts level", ser_cts, cl);
    check("R5 wait pulse", net_wait_stb, w5);
    @(posedge clk); #1;
    bus_wr = 0;
    ctrl_m = d;
  endtask

  task automatic wr_line(logic [7:0] d);
    logic to_ser, nto, lvl;
    @(posedge clk); #1;
    bus_addr = 16'h3C17; bus_wdata = d; bus_wr = 1;
    to_ser = ctrl_m[0];
    nto = ~ctrl_m[0];
    lvl = ~d[0];
    @(negedge clk);
    check("R7 serial strobe", ser_tx_stb, to_ser);
    check("R7 network strobe", net_tx_stb, nto);
    if (to_ser) check("R7 serial level", ser_tx_data, lvl);
    else        check("R7 network level", net_tx_data, lvl);
    @(posedge clk); #1;
    bus_wr = 0;
    if (to_ser) dtr_m = ~ser_dtr_in;
  endtask

  task automatic rd_line(string tag);
    logic b0;
    @(posedge clk); #1;
    bus_addr = 16'h0010; bus_rd = 1;
    b0 = ctrl_m[4] ? net_line_in : net_m;
    push(tag, {~ser_rxd_in, 6'b111111, b0});
    @(posedge clk); #1;
    bus_rd = 0;
    if (ctrl_m[4]) net_m = net_line_in;
  endtask

  task automatic rd_stat(string tag);
    @(posedge clk); #1;
    bus_addr = 16'hFFEF; bus_rd = 1;
    push(tag, {3'b111, net_busy_in, dtr_m, ~md_gap, ~md_sync, ~md_wprot});
    @(posedge clk); #1;
    bus_rd = 0;
  endtask

  task automatic frame(logic dtr);
    @(posedge clk); #1;
    ser_dtr_in = dtr; frame_tick = 1;
    @(posedge clk); #1;
    frame_tick = 0;
    dtr_m = ~dtr;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R2: reset levels and reset bytes
    @(negedge clk);
    check_levels("R2 reset levels");
    rd_stat("R2 reset status");
    rd_line("R2 reset line byte");
    // R7: reset routing goes to the network line
    wr_line(8'h00);
    // R3 R4 R5: same value, then wait bit low twice, then changes
    wr_ctrl(8'hEE);
    wr_ctrl(8'hCE);
    wr_ctrl(8'hCE);
    wr_ctrl(8'hDF);
    check_levels("R3 levels after write");
    // R9: serial write refreshes DTR
    ser_dtr_in = 0;
    wr_line(8'h01);
    md_gap = 1; net_busy_in = 1;
    rd_stat("R6 R9 status after serial write");
    // R8: CTS idle samples the network line
    ser_rxd_in = 0; net_line_in = 1;
    rd_line("R8 sampled network bit");
    wr_ctrl(8'hCF);
    net_line_in = 0;
    rd_line("R8 held network bit");
    // R9: frame tick refresh
    frame(1'b1);
    md_gap = 0; md_sync = 1; md_wprot = 1;
    rd_stat("R6 R9 status after frame tick");
    // R9: network-routed write does not refresh DTR
    ser_dtr_in = 0;
    wr_ctrl(8'hCE);
    wr_line(8'h01);
    rd_stat("R9 DTR held on network write");
    // R10: drive data port
    @(posedge clk); #1;
    bus_addr = 16'h1267; bus_wdata = 8'h5A; bus_wr = 1;
    @(negedge clk);
    check("R10 write valid", dd_wr_valid, 8'h01);
    check("R10 write data", dd_wr_data, 8'h5A);
    @(posedge clk); #1;
    bus_wr = 0; dd_rd_data = 8'hC3; bus_rd = 1;
    push("R10 read data", 8'hC3);
    @(negedge clk);
    check("R10 read request", dd_rd_req, 8'h01);
    @(posedge clk); #1;
    bus_rd = 0;
    // R11 R1: unclaimed cycles, high bits varied
    @(posedge clk); #1;
    bus_addr = 16'h7F18; bus_wdata = 8'h00; bus_wr = 1;
    @(negedge clk);
    check("R11 pass flag on write", pass_thru, 8'h01);
    check("R11 no strobes", {2'b00, drv_ctl_stb, cts_stb, net_wait_stb, ser_tx_stb, net_tx_stb, dd_wr_valid}, 8'h00);
    @(posedge clk); #1;
    bus_wr = 0; bus_addr = 16'h00F9; bus_rd = 1;
    @(negedge clk);
    check("R11 pass flag on read", pass_thru, 8'h01);
    check("R11 read not driven", bus_rdata_en, 8'h00);
    @(posedge clk); #1;
    bus_rd = 0;
    @(negedge clk);
    check_levels("R11 control unchanged");
    rd_line("R1 R11 line state unchanged");
    repeat (3) @(posedge clk);
    check("R1 all reads answered", exp_q.size(), 8'h00);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule